// File: doc/BRIEF.md
# Core Idle-State Sequencer

This block walks one processor core into and out of its idle levels: active (C0), halt (C1), clocks-off with caches flushed (C3) and power-gated with the architectural state saved (C6). An idle command carries the requested level number. Each deeper level repeats all steps of the level above it and then adds its own. Every step that involves an external agent waits for that agent's acknowledge before the next step starts. The agents are the cache flusher, the state save/restore engine and the power switch.

A wake input brings the core back to C0. If the core is already resident in an idle level, the exit runs in the reverse order of entry. C6 adds a power-on step, a settle wait set by a parameter, and a state restore. If wake arrives while an entry is still in progress, it is held. The step in progress finishes, no further step starts, and the sequencer unwinds from the depth it has reached.

A level number that has no implementation falls back to the nearest shallower level that does. Snoops stay serviceable while the core is active or halted, and through the flush itself.

Top module: `cstate_seq`

## Requirements
- R1: During and after reset the outputs show C0: pipeline running, both clock groups enabled, no flush, save or restore request, power gate on (gate-off low), snoop enable high.
- R2: An accepted request for C1 stops the pipeline and disables the main clock group one cycle after the request. The rest clock group and snoop enable stay high, and the state holds until wake.
- R3: The 3-bit level argument is a C-state number and maps as follows: 0 means no idle and is ignored; 1 and 2 map to C1; 3 to 5 map to C3; 6 and 7 map to C6, or to C3 when the C6 parameter is off. A request is ignored when wake is high in the same cycle or when the core is not in C0.
- R4: For C3 and C6 the halt step is followed by a flush request. The flush request holds until the flush acknowledge. Only after that acknowledge is the rest clock group disabled.
- R5: Snoop enable is high in C0, in C1 and during the flush. It falls in the cycle after the flush acknowledge, and rises again only when the rest clocks are restored on exit.
- R6: For C6, a save request follows C3 residency and holds until its acknowledge. Gate-off is asserted next and holds until the power-switch acknowledge.
- R7: Each waiting step holds its outputs unchanged for as long as its acknowledge is absent.
- R8: Wake during an entry is latched and takes effect at the next step boundary. No later entry step begins. An abort after flush or save returns to C0 through rest-clock enable and then main-clock enable, with no restore request.
- R9: Exit from C6 follows a fixed order: gate-off falls, the bench waits for the power acknowledge, then waits SETTLE_CYC cycles, then raises the restore request until its acknowledge, then enables the rest clocks, then enables the main clocks.
- R10: With every acknowledge returned in the cycle its request is first seen, the exit latency from wake to a running pipeline is 1 cycle from C1, 2 cycles from C3, and SETTLE_CYC+4 cycles from C6.
- R11: An acknowledge that arrives while its step is not waiting has no effect.
- R12: At most one of flush, save, restore and gate-off is asserted at a time. A running pipeline always has both clock groups on and the power gate on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_vld | input | 1 | Idle command strobe |
| req_lvl | input | 3 | Requested C-state number |
| wake | input | 1 | Wake / interrupt event |
| flush_ack | input | 1 | Cache flush finished |
| ctx_ack | input | 1 | State save or restore finished |
| pg_ack | input | 1 | Power switch reached its commanded state |
| pipe_stop | output | 1 | Stop the core pipeline |
| clk_main_en | output | 1 | Enable for the main clock group |
| clk_rest_en | output | 1 | Enable for the remaining clock group |
| flush_req | output | 1 | Request a flush of the core caches |
| save_req | output | 1 | Request architectural state save |
| restore_req | output | 1 | Request architectural state restore |
| pg_off | output | 1 | Command the core power gate off |
| snoop_en | output | 1 | Caches may answer external snoops |

## Verification
Every output comes straight from the registered sequencer state, so each result becomes visible at the first clock edge after the input that causes it. The bench drives inputs just after a falling edge and reads outputs at the next falling edge, so each step is checked exactly one edge later. Exit latencies are counted in falling edges from the cycle wake is driven: 1 for C1, 2 for C3 and SETTLE_CYC+4 for C6. In C6 the restore request must appear exactly SETTLE_CYC+1 edges after the power acknowledge is returned. The acknowledge model in the bench answers a request at the falling edge where it first sees it, and can be held off so that the waiting and abort paths can be tested.

// File: rtl/cstate_pkg.sv
package cstate_pkg;

  typedef enum logic [1:0] {
    LV_C0 = 2'd0,
    LV_C1 = 2'd1,
    LV_C3 = 2'd2,
    LV_C6 = 2'd3
  } lvl_e;

  typedef enum logic [3:0] {
    ST_RUN,
    ST_HALT,
    ST_FLUSH,
    ST_C3,
    ST_SAVE,
    ST_PGOFF,
    ST_C6,
    ST_PGON,
    ST_SETTLE,
    ST_RESTORE,
    ST_CLKON
  } seq_st_e;

  typedef struct packed {
    logic pipe_stop;
    logic clk_main;
    logic clk_rest;
    logic flush;
    logic save;
    logic restore;
    logic pg_off;
    logic snoop;
  } ctl_t;

  function automatic ctl_t ctl_of(seq_st_e s);
    ctl_t c;
    c = '{pipe_stop: 1'b1, clk_main: 1'b0, clk_rest: 1'b0, flush: 1'b0,
          save: 1'b0, restore: 1'b0, pg_off: 1'b0, snoop: 1'b0};
    case (s)
      ST_RUN: begin
        c.pipe_stop = 1'b0;
        c.clk_main  = 1'b1;
        c.clk_rest  = 1'b1;
        c.snoop     = 1'b1;
      end
      ST_HALT, ST_CLKON: begin
        c.clk_rest = 1'b1;
        c.snoop    = 1'b1;
      end
      ST_FLUSH: begin
        c.clk_rest = 1'b1;
        c.snoop    = 1'b1;
        c.flush    = 1'b1;
      end
      ST_SAVE:          c.save    = 1'b1;
      ST_PGOFF, ST_C6:  c.pg_off  = 1'b1;
      ST_RESTORE:       c.restore = 1'b1;
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/cstate_rst_sync.sv
module cstate_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = shift_q[STAGES-1];
endmodule

// File: rtl/cstate_lvl_map.sv
module cstate_lvl_map
  import cstate_pkg::*;
#(
  parameter int LVL_W  = 3,
  parameter bit C6_EN  = 1'b1
) (
  input  logic [LVL_W-1:0] arg,
  output lvl_e             lvl
);
  lvl_e deep_lvl;

  generate
    if (C6_EN) begin : g_deep_c6
      assign deep_lvl = LV_C6;
    end else begin : g_deep_c3
      assign deep_lvl = LV_C3;
    end
  endgenerate

  always_comb begin
    if (arg >= LVL_W'(6))      lvl = deep_lvl;
    else if (arg >= LVL_W'(3)) lvl = LV_C3;
    else if (arg != '0)        lvl = LV_C1;
    else                       lvl = LV_C0;
  end
endmodule

// File: rtl/cstate_settle.sv
module cstate_settle #(
  parameter int SETTLE_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic done
);
  localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign done   = (cnt_q == '0);
  assign cnt_en = load | (run & ~done);

  always_comb begin
    if (load) cnt_d = CW'(SETTLE_CYC - 1);
    else      cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cstate_fsm.sv
module cstate_fsm
  import cstate_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_vld,
  input  lvl_e    req_lvl,
  input  logic    wake,
  input  logic    flush_ack,
  input  logic    ctx_ack,
  input  logic    pg_ack,
  input  logic    settle_done,
  output seq_st_e state,
  output logic    settle_load,
  output logic    settle_run
);
  seq_st_e st_q, st_d;
  lvl_e    tgt_q;
  logic    tgt_en;
  logic    wpend_q, wpend_d;
  logic    wake_any;

  assign wake_any = wake | wpend_q;
  assign wpend_d  = (st_q != ST_RUN) & wake_any;
  assign tgt_en   = (st_q == ST_RUN) & req_vld & ~wake & (req_lvl != LV_C0);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_RUN:     if (tgt_en) st_d = ST_HALT;
      ST_HALT: begin
        if (wake_any)              st_d = ST_RUN;
        else if (tgt_q != LV_C1)   st_d = ST_FLUSH;
      end
      ST_FLUSH:   if (flush_ack) st_d = wake_any ? ST_CLKON : ST_C3;
      ST_C3: begin
        if (wake_any)              st_d = ST_CLKON;
        else if (tgt_q == LV_C6)   st_d = ST_SAVE;
      end
      ST_SAVE:    if (ctx_ack)   st_d = wake_any ? ST_CLKON : ST_PGOFF;
      ST_PGOFF:   if (pg_ack)    st_d = wake_any ? ST_PGON : ST_C6;
      ST_C6:      if (wake_any)  st_d = ST_PGON;
      ST_PGON:    if (pg_ack)    st_d = ST_SETTLE;
      ST_SETTLE:  if (settle_done) st_d = ST_RESTORE;
      ST_RESTORE: if (ctx_ack)   st_d = ST_CLKON;
      ST_CLKON:   st_d = ST_RUN;
      default:    st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_RUN;
      wpend_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      wpend_q <= wpend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tgt_q <= LV_C0;
    else if (tgt_en) tgt_q <= req_lvl;
  end

  assign state       = st_q;
  assign settle_load = (st_q == ST_PGON) & pg_ack;
  assign settle_run  = (st_q == ST_SETTLE);
endmodule

// File: rtl/cstate_seq.sv
module cstate_seq
  import cstate_pkg::*;
#(
  parameter int LVL_W      = 3,
  parameter bit C6_EN      = 1'b1,
  parameter int SETTLE_CYC = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_vld,
  input  logic [LVL_W-1:0] req_lvl,
  input  logic             wake,
  input  logic             flush_ack,
  input  logic             ctx_ack,
  input  logic             pg_ack,
  output logic             pipe_stop,
  output logic             clk_main_en,
  output logic             clk_rest_en,
  output logic             flush_req,
  output logic             save_req,
  output logic             restore_req,
  output logic             pg_off,
  output logic             snoop_en
);
  logic    rst_q_n;
  lvl_e    lvl_m;
  seq_st_e st;
  logic    s_load, s_run, s_done;
  ctl_t    ctl;

  cstate_rst_sync #(.STAGES(SYNC_STAGES)) i_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  cstate_lvl_map #(.LVL_W(LVL_W), .C6_EN(C6_EN)) i_map (
    .arg(req_lvl), .lvl(lvl_m)
  );

  cstate_settle #(.SETTLE_CYC(SETTLE_CYC)) i_settle (
    .clk(clk), .rst_n(rst_q_n), .load(s_load), .run(s_run), .done(s_done)
  );

  cstate_fsm i_fsm (
    .clk(clk), .rst_n(rst_q_n), .req_vld(req_vld), .req_lvl(lvl_m),
    .wake(wake), .flush_ack(flush_ack), .ctx_ack(ctx_ack), .pg_ack(pg_ack),
    .settle_done(s_done), .state(st), .settle_load(s_load), .settle_run(s_run)
  );

  always_comb ctl = ctl_of(st);

  assign pipe_stop   = ctl.pipe_stop;
  assign clk_main_en = ctl.clk_main;
  assign clk_rest_en = ctl.clk_rest;
  assign flush_req   = ctl.flush;
  assign save_req    = ctl.save;
  assign restore_req = ctl.restore;
  assign pg_off      = ctl.pg_off;
  assign snoop_en    = ctl.snoop;
endmodule

// File: rtl/cstate_seq_chk.sv
module cstate_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic flush_ack,
  input logic ctx_ack,
  input logic pipe_stop,
  input logic clk_main_en,
  input logic clk_rest_en,
  input logic flush_req,
  input logic save_req,
  input logic restore_req,
  input logic pg_off,
  input logic snoop_en
);
  // R4 / R7: flush request holds while unacknowledged
  a_r4_flush_wait: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req && !flush_ack |=> flush_req);

  // R4: rest clocks drop only after a flush acknowledge
  a_r4_clk_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_rest_en) |-> $past(flush_req && flush_ack));

  // R5: snoops stop only after the flush completed
  a_r5_snoop_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(snoop_en) |-> $past(flush_ack));

  // R6: gate-off only after an acknowledged save
  a_r6_gate_after_save: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_off) |-> $past(save_req && ctx_ack));

  // R7: save request holds while unacknowledged
  a_r7_save_wait: assert property (@(posedge clk) disable iff (!rst_n)
    save_req && !ctx_ack |=> save_req);

  // R9: restore starts on a powered, clock-stopped core
  a_r9_restore_unclocked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(restore_req) |-> $past(!pg_off && !clk_rest_en));

  // R2 / R8: main clocks return only after rest clocks and snoops
  a_r2_main_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_main_en) |-> $past(clk_rest_en && snoop_en));

  // R12: one agent request at a time
  a_r12_one_req: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flush_req, save_req, restore_req, pg_off}));

  // R12: running pipeline implies full clocks and power
  a_r12_run_ok: assert property (@(posedge clk) disable iff (!rst_n)
    !pipe_stop |-> clk_main_en && clk_rest_en && !pg_off);
endmodule

bind cstate_seq cstate_seq_chk i_chk (
  .clk(clk), .rst_n(rst_q_n), .flush_ack(flush_ack), .ctx_ack(ctx_ack),
  .pipe_stop(pipe_stop), .clk_main_en(clk_main_en), .clk_rest_en(clk_rest_en),
  .flush_req(flush_req), .save_req(save_req), .restore_req(restore_req),
  .pg_off(pg_off), .snoop_en(snoop_en)
);

// File: tb/test_cstate_seq.sv
`timescale 1ns/1ps
module test_cstate_seq;
  localparam int S = 8;
  // observation order: pipe_stop, clk_main, clk_rest, flush, save, restore, pg_off, snoop
  localparam logic [7:0] O_C0 = 8'b0110_0001;
  localparam logic [7:0] O_C1 = 8'b1010_0001;
  localparam logic [7:0] O_FL = 8'b1011_0001;
  localparam logic [7:0] O_C3 = 8'b1000_0000;
  localparam logic [7:0] O_SV = 8'b1000_1000;
  localparam logic [7:0] O_PG = 8'b1000_0010;

  logic clk = 1'b0;
  logic rst_n, req_vld, wake, flush_ack, ctx_ack, pg_ack;
  logic [2:0] req_lvl;
  logic pipe_stop, clk_main_en, clk_rest_en, flush_req, save_req, restore_req, pg_off, snoop_en;
  logic [7:0] obs;
  logic af, ac, ap, pg_seen;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign obs = {pipe_stop, clk_main_en, clk_rest_en, flush_req, save_req, restore_req, pg_off, snoop_en};

  cstate_seq #(.SETTLE_CYC(S)) i_cstate_seq (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_lvl(req_lvl), .wake(wake),
    .flush_ack(flush_ack), .ctx_ack(ctx_ack), .pg_ack(pg_ack),
    .pipe_stop(pipe_stop), .clk_main_en(clk_main_en), .clk_rest_en(clk_rest_en),
    .flush_req(flush_req), .save_req(save_req), .restore_req(restore_req),
    .pg_off(pg_off), .snoop_en(snoop_en)
  );

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // step to next falling edge and answer agent requests
  task automatic tick();
    @(negedge clk);
    flush_ack = af & flush_req;
    ctx_ack   = ac & (save_req | restore_req);
    if (ap && (pg_off != pg_seen)) begin
      pg_ack  = 1'b1;
      pg_seen = pg_off;
    end else pg_ack = 1'b0;
  endtask

  task automatic go(input logic [2:0] lvl);
    req_vld = 1'b1; req_lvl = lvl;
    tick();
    req_vld = 1'b0;
  endtask

  task automatic wake_count(output int n);
    n = 0;
    wake = 1'b1;
    do begin
      tick();
      wake = 1'b0;
      n++;
    end while (pipe_stop && n < 200);
  endtask

  task automatic t_reset();
    chk("R1 outputs in reset", obs, O_C0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R1 outputs after reset", obs, O_C0);
  endtask

  task automatic t_c1();
    int n;
    go(3'd1);
    chk("R2 halt entry", obs, O_C1);
    repeat (5) tick();
    chk("R2 halt holds", obs, O_C1);
    wake_count(n);
    chk("R10 C1 exit latency", n, 1);
    chk("R10 C1 exit outputs", obs, O_C0);
  endtask

  task automatic t_map();
    int n;
    go(3'd0);
    repeat (3) tick();
    chk("R3 level 0 ignored", obs, O_C0);
    wake = 1'b1; go(3'd1); wake = 1'b0;
    chk("R3 request with wake ignored", obs, O_C0);
    go(3'd2);
    repeat (4) tick();
    chk("R3 level 2 acts as C1", obs, O_C1);
    go(3'd6);
    repeat (3) tick();
    chk("R3 request outside C0 ignored", obs, O_C1);
    wake_count(n);
    go(3'd4);
    repeat (5) tick();
    chk("R3 level 4 acts as C3", obs, O_C3);
    wake_count(n);
    chk("R10 C3 exit latency", n, 2);
  endtask

  task automatic t_c3();
    int n;
    af = 1'b0;
    go(3'd3);
    tick();
    chk("R4 flush requested", obs, O_FL);
    repeat (6) tick();
    chk("R7 flush wait holds, R5 snoop on", obs, O_FL);
    af = 1'b1;
    tick();
    tick();
    chk("R4 R5 clocks and snoop off after flush", obs, O_C3);
    wake = 1'b1; tick(); wake = 1'b0;
    chk("R5 snoop back with rest clocks", obs, O_C1);
    tick();
    chk("R8 main clocks last", obs, O_C0);
  endtask

  task automatic t_c6();
    int n, r_at, k_at;
    go(3'd6);
    tick(); chk("R6 flush step", obs, O_FL);
    tick(); chk("R6 C3 step", obs, O_C3);
    tick(); chk("R6 save step", obs, O_SV);
    tick(); chk("R6 gate-off step", obs, O_PG);
    repeat (4) tick();
    chk("R6 C6 resident", obs, O_PG);
    n = 0; r_at = 0; k_at = 0;
    wake = 1'b1;
    do begin
      tick();
      wake = 1'b0;
      n++;
      if (restore_req && r_at == 0) r_at = n;
      if (clk_rest_en && k_at == 0) k_at = n;
    end while (pipe_stop && n < 200);
    chk("R9 restore after settle", r_at, S + 2);
    chk("R9 rest clocks after restore", k_at, S + 3);
    chk("R10 C6 exit latency", n, S + 4);
  endtask

  task automatic t_abort_flush();
    int n;
    bit rest_off, saw_save;
    af = 1'b0;
    go(3'd6);
    tick();
    wake = 1'b1; tick(); wake = 1'b0;
    chk("R8 flush completes before abort", obs, O_FL);
    af = 1'b1;
    n = 0; rest_off = 0; saw_save = 0;
    do begin
      tick();
      n++;
      if (!clk_rest_en) rest_off = 1;
      if (save_req) saw_save = 1;
    end while (pipe_stop && n < 200);
    chk("R8 abort after flush latency", n, 3);
    chk("R8 rest clocks never stopped", rest_off, 0);
    chk("R8 no save after abort", saw_save, 0);
  endtask

  task automatic t_abort_save();
    int n;
    bit saw_pg, saw_rs;
    ac = 1'b0;
    go(3'd7);
    repeat (3) tick();
    chk("R6 level 7 reaches save", obs, O_SV);
    wake = 1'b1; tick(); wake = 1'b0;
    chk("R7 save holds during abort", obs, O_SV);
    ac = 1'b1;
    n = 0; saw_pg = 0; saw_rs = 0;
    do begin
      tick();
      n++;
      if (pg_off) saw_pg = 1;
      if (restore_req) saw_rs = 1;
    end while (pipe_stop && n < 200);
    chk("R8 abort after save latency", n, 3);
    chk("R8 no gate-off after abort", saw_pg, 0);
    chk("R8 no restore after abort", saw_rs, 0);
  endtask

  task automatic t_stray();
    int n;
    af = 1'b0; ac = 1'b0; ap = 1'b0;
    flush_ack = 1'b1; ctx_ack = 1'b1; pg_ack = 1'b1;
    tick();
    tick();
    chk("R11 stray acks in C0", obs, O_C0);
    go(3'd1);
    flush_ack = 1'b1; ctx_ack = 1'b1; pg_ack = 1'b1;
    tick();
    tick();
    chk("R11 stray acks in C1", obs, O_C1);
    af = 1'b1; ac = 1'b1; ap = 1'b1;
    wake_count(n);
    chk("R11 C1 exit after stray acks", obs, O_C0);
  endtask

  initial begin
    rst_n = 1'b0; req_vld = 1'b0; req_lvl = '0; wake = 1'b0;
    flush_ack = 1'b0; ctx_ack = 1'b0; pg_ack = 1'b0;
    af = 1'b1; ac = 1'b1; ap = 1'b1; pg_seen = 1'b0;
    @(negedge clk);
    t_reset();
    t_c1();
    t_map();
    t_c3();
    t_c6();
    t_abort_flush();
    t_abort_save();
    t_stray();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule